// File: doc/BRIEF.md
# Redirection table register window

This block holds a table of 64-bit interrupt redirection entries, one per input pin, together with an identity register and a fixed version register, and makes all of them reachable through two 32-bit locations on a memory-mapped bus. Software first writes a select value into the select location. It then reads or writes the data window, which reaches whichever internal register the select value names. Each 64-bit entry is reached as two 32-bit halves. An odd select value names the upper half and an even select value names the lower half.

The entry contents go as one flat vector to a separate interrupt-service block. That block reports its own progress back through three per-pin inputs: set the remote-pending bit, clear that bit, and the live delivery-busy status. Neither of these status bits can be changed by a bus write. After every accepted table write the window pulses a service request, so that the service block can scan the table again.

Top module: `redir_window`

## Requirements
- R1: After reset every entry reads 0x0001_0000 in its low half (bit 16, mask, set) and 0 in its high half. The select register and the ID are 0, and `svc_req` is low.
- R2: Only address bits 7:0 are decoded. Offset 0x00 is the select register: a write of any size stores wdata[7:0], and a read returns it zero-extended. Offset 0x10 is the data window. Any other offset reads 0.
- R3: A window access whose size is not 4 bytes is ignored. A write changes no state and raises no service request, and a read returns 0.
- R4: Select 0 is the identity register, with the ID in bits 27:24. Select 2 reads the same value, and writes to select 2 are discarded.
- R5: Select 1 is read-only and returns VERSION | ((NUM_PINS-1) << 16), which is 0x0017_0020 with the default parameters.
- R6: For a select value of 0x10 or above, the entry index is (select-0x10)>>1. An odd select reads or writes bits 63:32 of that entry and an even select reaches bits 31:0. The other half is left unchanged.
- R7: A select whose index is NUM_PINS or more, and selects 3 to 15, read 0. Writes through them change nothing and raise no service request.
- R8: Bit 12 (delivery busy) and bit 14 (remote pending) of an entry cannot be changed by any written data.
- R9: After a table write, if bit 15 (trigger, 0 = edge) of the resulting entry is 0, bit 14 is cleared.
- R10: `svc_req` is high for exactly the one cycle after each accepted table write.
- R11: Read data and `bus_rvalid` are registered and are valid in the cycle after the request. A read changes no state.
- R12: Bit 14 of entry i is set by `rirr_set[i]` and cleared by `rirr_clr[i]`. Bit 12 follows `dlv_busy[i]` one cycle later. Entry i appears on `tbl_flat[64*i+63:64*i]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_en | input | 1 | Access request |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address; only bits 7:0 decoded |
| bus_size | input | 3 | Access size in bytes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data |
| bus_rvalid | output | 1 | Read data valid |
| rirr_set | input | NUM_PINS | Set remote-pending bit per entry |
| rirr_clr | input | NUM_PINS | Clear remote-pending bit per entry |
| dlv_busy | input | NUM_PINS | Delivery-busy status per entry |
| svc_req | output | 1 | Rescan pulse after a table write |
| tbl_flat | output | 64*NUM_PINS | All entries, entry i at bits 64*i+63:64*i |

## Verification
Every result of a bus access arrives one clock edge after the request: read data, `bus_rvalid`, the `svc_req` pulse and the updated entry on `tbl_flat`. The bench drives a request at a falling edge and removes it at the next falling edge. It samples at that same falling edge, which falls half a period after the register edge. Status inputs also take one edge, so every status change is followed by at least one idle cycle before the entry is read back. The absence of a second `svc_req` cycle is checked one falling edge later.

// File: rtl/redir_window.sv
module redir_window #(
  parameter int         NUM_PINS = 24,
  parameter int         ADDR_W   = 12,
  parameter int         ID_W     = 4,
  parameter logic [7:0] VERSION  = 8'h20,
  parameter logic [7:0] SEL_OFS  = 8'h00,
  parameter logic [7:0] WIN_OFS  = 8'h10
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     bus_en,
  input  logic                     bus_we,
  input  logic [ADDR_W-1:0]        bus_addr,
  input  logic [2:0]               bus_size,
  input  logic [31:0]              bus_wdata,
  output logic [31:0]              bus_rdata,
  output logic                     bus_rvalid,
  input  logic [NUM_PINS-1:0]      rirr_set,
  input  logic [NUM_PINS-1:0]      rirr_clr,
  input  logic [NUM_PINS-1:0]      dlv_busy,
  output logic                     svc_req,
  output logic [64*NUM_PINS-1:0]   tbl_flat
);

  localparam logic [63:0] ENTRY_RST = 64'h0000_0000_0001_0000;
  localparam logic [6:0]  NPINS7    = 7'(NUM_PINS);
  localparam logic [31:0] VER_WORD  = 32'(VERSION) | (32'(NUM_PINS - 1) << 16);
  localparam int          B_BUSY = 12, B_RIRR = 14, B_TRIG = 15;

  logic [7:0]    sel;
  logic [ID_W-1:0] id;
  logic [63:0]   tbl    [NUM_PINS];
  logic [63:0]   tbl_nx [NUM_PINS];
  logic [31:0]   rd_nx;
  logic [31:0]   half_rd;
  logic [NUM_PINS-1:0] wr_hit;

  wire [7:0] sel_off  = sel - 8'h10;
  wire [6:0] tidx     = sel_off[7:1];
  wire       tbl_hit  = (sel >= 8'h10) && (tidx < NPINS7);
  wire       at_sel   = bus_addr[7:0] == SEL_OFS;
  wire       at_win   = bus_addr[7:0] == WIN_OFS;
  wire       size_ok  = bus_size == 3'd4;
  wire       win_wr   = bus_en && bus_we && at_win && size_ok;
  wire       tbl_wr   = win_wr && tbl_hit;
  wire       rd_req   = bus_en && !bus_we;
  wire       unused_ok = &{1'b0, sel_off[0], bus_addr[ADDR_W-1:8]};

  always_comb begin
    for (int i = 0; i < NUM_PINS; i++) begin
      logic [63:0] e;
      logic        rp;
      e  = tbl[i];
      rp = (e[B_RIRR] | rirr_set[i]) & ~rirr_clr[i];
      if (wr_hit[i]) begin
        if (sel[0]) e[63:32] = bus_wdata;
        else        e[31:0]  = bus_wdata;
      end
      e[B_RIRR] = rp && !(wr_hit[i] && !e[B_TRIG]);
      e[B_BUSY] = dlv_busy[i];
      tbl_nx[i] = e;
    end
  end

  always_comb begin
    half_rd = '0;
    for (int i = 0; i < NUM_PINS; i++)
      if (tidx == 7'(i)) half_rd = sel[0] ? tbl[i][63:32] : tbl[i][31:0];
  end

  always_comb begin
    rd_nx = '0;
    if (at_sel) rd_nx = {24'b0, sel};
    else if (at_win && size_ok) begin
      case (sel)
        8'h00, 8'h02: rd_nx = 32'(id) << 24;
        8'h01:        rd_nx = VER_WORD;
        default:      rd_nx = tbl_hit ? half_rd : 32'b0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel        <= '0;
      id         <= '0;
      svc_req    <= 1'b0;
      bus_rvalid <= 1'b0;
      bus_rdata  <= '0;
      for (int i = 0; i < NUM_PINS; i++) tbl[i] <= ENTRY_RST;
    end else begin
      if (bus_en && bus_we && at_sel) sel <= bus_wdata[7:0];
      if (win_wr && sel == 8'h00) id <= bus_wdata[24 +: ID_W];
      svc_req    <= tbl_wr;
      bus_rvalid <= rd_req;
      if (rd_req) bus_rdata <= rd_nx;
      for (int i = 0; i < NUM_PINS; i++) tbl[i] <= tbl_nx[i];
    end
  end

  genvar g;
  generate
    for (g = 0; g < NUM_PINS; g++) begin : g_pin
      assign wr_hit[g] = tbl_wr && (tidx == 7'(g));
      assign tbl_flat[64*g +: 64] = tbl[g];

      p_ro_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit[g] && !rirr_set[g] && !rirr_clr[g] |=>
          tbl[g][B_RIRR] == ($past(tbl[g][B_RIRR]) && tbl[g][B_TRIG]));

      p_edge_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
        wr_hit[g] |=> (tbl[g][B_TRIG] || !tbl[g][B_RIRR]));
    end
  endgenerate

  p_svc_after_write_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tbl_wr |=> svc_req);

  p_badsize_nowrite_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && bus_we && at_win && !size_ok |=> !svc_req);

  p_badsize_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && !bus_we && at_win && !size_ok |=> bus_rdata == 32'b0);

  p_rvalid_r11: assert property (@(posedge clk) disable iff (!rst_n)
    bus_en && !bus_we |=> bus_rvalid);

endmodule

// File: tb/redir_window_bench.sv
`timescale 1ns/100ps
module redir_window_bench;
  localparam int NP = 24;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_en = 1'b0, bus_we = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [2:0]  bus_size = 3'd4;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        bus_rvalid;
  logic [NP-1:0] rirr_set = '0, rirr_clr = '0, dlv_busy = '0;
  logic          svc_req;
  logic [64*NP-1:0] tbl_flat;

  int total = 0, bad = 0;

  always #2.5 clk = ~clk;

  redir_window u_redir_window (
    .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_size(bus_size), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid), .rirr_set(rirr_set),
    .rirr_clr(rirr_clr), .dlv_busy(dlv_busy), .svc_req(svc_req),
    .tbl_flat(tbl_flat));

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [2:0] sz, input logic [31:0] d,
                    output logic svc);
    @(negedge clk);
    bus_en = 1; bus_we = 1; bus_addr = a; bus_size = sz; bus_wdata = d;
    @(negedge clk);
    bus_en = 0; bus_we = 0;
    svc = svc_req;
  endtask

  task automatic rd(input logic [11:0] a, input logic [2:0] sz, output logic [31:0] d);
    @(negedge clk);
    bus_en = 1; bus_we = 0; bus_addr = a; bus_size = sz;
    @(negedge clk);
    bus_en = 0;
    d = bus_rdata;
    check("R11 rvalid", {63'b0, bus_rvalid}, 64'd1);
  endtask

  task automatic sel_to(input logic [7:0] s);
    logic sv;
    wr(12'h000, 3'd1, {24'b0, s}, sv);
  endtask

  task automatic win_rd(input logic [7:0] s, output logic [31:0] d);
    sel_to(s);
    rd(12'h010, 3'd4, d);
  endtask

  task automatic win_wr(input logic [7:0] s, input logic [31:0] v, output logic svc);
    sel_to(s);
    wr(12'h010, 3'd4, v, svc);
  endtask

  task automatic pulse(input bit is_set, input int pin);
    @(negedge clk);
    if (is_set) rirr_set[pin] = 1; else rirr_clr[pin] = 1;
    @(negedge clk);
    rirr_set = '0; rirr_clr = '0;
  endtask

  task automatic t_reset;
    logic [31:0] d;
    check("R1 svc_req", {63'b0, svc_req}, 0);
    check("R1 entry0 flat", tbl_flat[63:0], 64'h0000_0000_0001_0000);
    rd(12'h000, 3'd4, d);       check("R1 select", d, 0);
    win_rd(8'h10, d);           check("R1 entry0 low", d, 32'h0001_0000);
    win_rd(8'h3F, d);           check("R1 entry23 high", d, 0);
    win_rd(8'h00, d);           check("R1 id", d, 0);
  endtask

  task automatic t_select;
    logic [31:0] d;
    logic sv;
    wr(12'h000, 3'd1, 32'hFFFF_FF15, sv);
    rd(12'h000, 3'd4, d);       check("R2 select readback", d, 32'h15);
    wr(12'hF00, 3'd2, 32'h12, sv);
    rd(12'h000, 3'd1, d);       check("R2 upper addr bits ignored", d, 32'h12);
    rd(12'h004, 3'd4, d);       check("R2 other offset", d, 0);
  endtask

  task automatic t_id;
    logic [31:0] d;
    logic sv;
    win_wr(8'h00, 32'h0A00_0000, sv);
    win_rd(8'h00, d);           check("R4 id write", d, 32'h0A00_0000);
    win_wr(8'h02, 32'h0500_0000, sv);
    win_rd(8'h02, d);           check("R4 arb reads id", d, 32'h0A00_0000);
    win_rd(8'h00, d);           check("R4 arb write discarded", d, 32'h0A00_0000);
  endtask

  task automatic t_version;
    logic [31:0] d;
    logic sv;
    win_rd(8'h01, d);           check("R5 version", d, 32'h0017_0020);
    win_wr(8'h01, 32'h0, sv);
    win_rd(8'h01, d);           check("R5 version read-only", d, 32'h0017_0020);
  endtask

  task automatic t_table;
    logic [31:0] d;
    logic sv;
    win_wr(8'h1A, 32'h0000_A0B1, sv);
    check("R10 svc after low write", {63'b0, sv}, 1);
    @(negedge clk);
    check("R10 svc single cycle", {63'b0, svc_req}, 0);
    win_wr(8'h1B, 32'hDEAD_BEEF, sv);
    check("R10 svc after high write", {63'b0, sv}, 1);
    win_rd(8'h1B, d);           check("R6 high half", d, 32'hDEAD_BEEF);
    win_rd(8'h1A, d);           check("R6 low half kept", d, 32'h0000_A0B1);
    check("R12 flat export", tbl_flat[5*64 +: 64], 64'hDEAD_BEEF_0000_A0B1);
  endtask

  task automatic t_bad_size;
    logic [31:0] d;
    logic sv;
    sel_to(8'h1A);
    wr(12'h010, 3'd2, 32'h0, sv);
    check("R3 no svc on bad size", {63'b0, sv}, 0);
    rd(12'h010, 3'd2, d);       check("R3 bad size read zero", d, 0);
    rd(12'h010, 3'd4, d);       check("R3 bad size write ignored", d, 32'h0000_A0B1);
  endtask

  task automatic t_range;
    logic [31:0] d;
    logic sv;
    logic [64*NP-1:0] snap;
    snap = tbl_flat;
    win_wr(8'h40, 32'hFFFF_FFFF, sv);
    check("R7 out of range no svc", {63'b0, sv}, 0);
    check("R7 out of range no change", tbl_flat == snap, 1);
    win_rd(8'h40, d);           check("R7 out of range read", d, 0);
    win_wr(8'h05, 32'hFFFF_FFFF, sv);
    check("R7 gap select no svc", {63'b0, sv}, 0);
    win_rd(8'h05, d);           check("R7 gap select read", d, 0);
    win_wr(8'h3E, 32'h0000_5234, sv);
    win_rd(8'h3E, d);           check("R8 last entry ro bits", d, 32'h0000_0234);
  endtask

  task automatic t_status;
    logic [31:0] d;
    logic sv;
    pulse(1, 5);
    win_rd(8'h1A, d);           check("R12 rirr set", d, 32'h0000_E0B1);
    win_wr(8'h1A, 32'h0000_A0B2, sv);
    win_rd(8'h1A, d);           check("R8 rirr survives write", d, 32'h0000_E0B2);
    @(negedge clk); dlv_busy[5] = 1;
    win_wr(8'h1A, 32'h0000_A0B2, sv);
    win_rd(8'h1A, d);           check("R8 busy not writable", d, 32'h0000_F0B2);
    @(negedge clk); dlv_busy[5] = 0;
    @(negedge clk);
    win_rd(8'h1A, d);           check("R12 busy follows input", d, 32'h0000_E0B2);
    pulse(0, 5);
    win_rd(8'h1A, d);           check("R12 rirr clear", d, 32'h0000_A0B2);
    pulse(1, 5);
    win_wr(8'h1A, 32'h0000_6077, sv);
    win_rd(8'h1A, d);           check("R9 edge write clears rirr", d, 32'h0000_2077);
    pulse(1, 5);
    win_rd(8'h1A, d);           check("R12 rirr set on edge entry", d, 32'h0000_6077);
    win_wr(8'h1B, 32'h0, sv);
    win_rd(8'h1A, d);           check("R9 high-half write clears rirr", d, 32'h0000_2077);
  endtask

  task automatic t_read_quiet;
    logic [31:0] d1, d2;
    logic [64*NP-1:0] snap;
    win_rd(8'h1A, d1);
    snap = tbl_flat;
    check("R11 no svc after read", {63'b0, svc_req}, 0);
    rd(12'h010, 3'd4, d2);
    check("R11 repeated read same", d2, d1);
    check("R11 read leaves table", tbl_flat == snap, 1);
  endtask

  initial begin
    #200000;
    bad++; total++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset();
    t_select();
    t_id();
    t_version();
    t_table();
    t_bad_size();
    t_range();
    t_status();
    t_read_quiet();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule